// File: doc/BRIEF.md
# Reset-Pulse Sleep Controller

This block turns a single active-low pin into a low-power control for a motor gate-drive chip. A short low glitch on the pin does nothing. The controller goes to sleep only when the pin stays low for more than a set number of clock cycles. In sleep it removes the enable from the internal circuitry, including the pump regulator, and it clears every latched fault flag.

When the pin returns high, the controller leaves sleep but still holds the gate drive off. It waits for the charge-pump monitor to report that the supply is ready, and only then returns to normal operation. While it waits, a new low pulse on the pin is qualified from the start again.

The pin passes through a two-flop synchronizer. The qualifying time is a parameter, counted in clock cycles.

Top module: `reset_sleep_ctrl`

## Requirements
- R1: When the system reset is released, the controller waits for the pump: `sleepState`=0, `gateEn`=0, `circuitEn`=1 and `faultFlags`=0.
- R2: A low level on `pinN` seen at `PULSE_CYCLES` or fewer consecutive rising clock edges is ignored. It changes neither the operating state nor `faultFlags`.
- R3: A low level on `pinN` seen at `PULSE_CYCLES`+1 consecutive rising edges sets `sleepState`. It rises at the edge `PULSE_CYCLES`+3 edges after the first edge that samples the pin low.
- R4: While `sleepState` is 1, both `circuitEn` and `gateEn` are 0.
- R5: Every bit of `faultFlags` reads 0 from the cycle in which `sleepState` rises.
- R6: After `pinN` returns high, `sleepState` falls and `gateEn` stays 0 for as long as `pumpReady` is 0. `gateEn` rises at the first edge that samples `pumpReady` high.
- R7: Bit i of `faultEvt`, sampled high at an edge while `gateEn` is 1, sets bit i of `faultFlags`. The bit stays set until sleep is entered. Events sampled while `gateEn` is 0 are ignored.
- R8: A low pulse on `pinN` that starts while the controller waits for the pump is qualified from zero by the same length rule as R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low system reset |
| pinN | input | 1 | Active-low sleep request pin, asynchronous to `clk` |
| pumpReady | input | 1 | Charge-pump supply-ready indication |
| faultEvt | input | NUM_FAULTS | Raw fault event strobes, one bit per fault |
| sleepState | output | 1 | 1 while the controller is asleep |
| circuitEn | output | 1 | Enable for the internal circuitry and the pump regulator |
| gateEn | output | 1 | Permission for the gate drivers to switch |
| faultFlags | output | NUM_FAULTS | Latched fault flags |

## Verification
The bench builds the block with `PULSE_CYCLES`=6 and `NUM_FAULTS`=4. With these values, low pulses one cycle below, exactly at and one cycle above the qualifying limit fit into a short table of vectors. Each fault bit can also be set, accumulated and cleared on its own. Because the qualifying window is short, the bench can also repeat the qualification inside the pump-wait window and hold the pump-ready input low for a long stretch.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SLEEP  = 2'd2
  } slpState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchEn;     // fault events may be latched this cycle
    logic clearFaults; // sleep is entered at this edge
  } slpCtl_s;

endpackage

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int PULSE_CYCLES = 8,
  parameter int NUM_FAULTS   = 4
) (
  input  logic                  clk,
  input  logic                  sysRstN,
  input  logic                  pinN,
  input  logic [NUM_FAULTS-1:0] faultEvt,
  input  slpCtl_s               ctl,
  output logic                  qualify,
  output logic                  pinHigh,
  output logic [NUM_FAULTS-1:0] faultFlags
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PULSE_CYCLES);

  logic          pinMeta;
  logic          pinSync;
  logic [CW-1:0] lowCnt;

  // two-flop synchronizer, idle level is high (awake)
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      pinMeta <= 1'b1;
      pinSync <= 1'b1;
    end else begin
      pinMeta <= pinN;
      pinSync <= pinMeta;
    end
  end

  // width of the current low pulse, saturating at the limit
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      lowCnt <= '0;
    end else if (pinSync) begin
      lowCnt <= '0;
    end else if (lowCnt != LIMIT) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign pinHigh = pinSync;
  assign qualify = !pinSync && (lowCnt == LIMIT);

  // one sticky latch per fault
  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_flag
    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN) begin
        faultFlags[i] <= 1'b0;
      end else if (ctl.clearFaults) begin
        faultFlags[i] <= 1'b0;
      end else if (ctl.latchEn && faultEvt[i]) begin
        faultFlags[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/slp_control.sv
module slp_control
  import slp_pkg::*;
(
  input  logic    clk,
  input  logic    sysRstN,
  input  logic    qualify,
  input  logic    pinHigh,
  input  logic    pumpReady,
  output slpCtl_s ctl,
  output logic    sleepState,
  output logic    circuitEn,
  output logic    gateEn
);

  slpState_e state;
  slpState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ACTIVE: if (qualify) stateNext = ST_SLEEP;
      ST_SLEEP:  if (pinHigh) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (qualify)        stateNext = ST_SLEEP;
        else if (pumpReady) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) state <= ST_WAIT;
    else          state <= stateNext;
  end

  always_comb begin
    ctl.latchEn     = (state == ST_ACTIVE);
    ctl.clearFaults = (state != ST_SLEEP) && (stateNext == ST_SLEEP);
  end

  assign sleepState = (state == ST_SLEEP);
  assign circuitEn  = (state != ST_SLEEP);
  assign gateEn     = (state == ST_ACTIVE);

endmodule

// File: rtl/reset_sleep_ctrl.sv
module reset_sleep_ctrl
  import slp_pkg::*;
#(
  parameter int PULSE_CYCLES = 8,
  parameter int NUM_FAULTS   = 4
) (
  input  logic                  clk,
  input  logic                  sysRstN,
  input  logic                  pinN,
  input  logic                  pumpReady,
  input  logic [NUM_FAULTS-1:0] faultEvt,
  output logic                  sleepState,
  output logic                  circuitEn,
  output logic                  gateEn,
  output logic [NUM_FAULTS-1:0] faultFlags
);

  slpCtl_s ctl;
  logic    qualify;
  logic    pinHigh;

  slp_datapath #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .NUM_FAULTS  (NUM_FAULTS)
  ) u_dp (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .pinN      (pinN),
    .faultEvt  (faultEvt),
    .ctl       (ctl),
    .qualify   (qualify),
    .pinHigh   (pinHigh),
    .faultFlags(faultFlags)
  );

  slp_control u_ctl (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .qualify   (qualify),
    .pinHigh   (pinHigh),
    .pumpReady (pumpReady),
    .ctl       (ctl),
    .sleepState(sleepState),
    .circuitEn (circuitEn),
    .gateEn    (gateEn)
  );

endmodule

// File: rtl/reset_sleep_ctrl_chk.sv
module reset_sleep_ctrl_chk #(
  parameter int NUM_FAULTS = 4
) (
  input logic                  clk,
  input logic                  sysRstN,
  input logic                  pumpReady,
  input logic                  sleepState,
  input logic                  circuitEn,
  input logic                  gateEn,
  input logic [NUM_FAULTS-1:0] faultFlags
);

  p_off_in_sleep_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    sleepState |-> (!gateEn && !circuitEn));

  p_clear_on_sleep_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(sleepState) |-> (faultFlags == '0));

  p_gate_needs_pump_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(gateEn) |-> $past(pumpReady));

  p_wake_gate_off_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(sleepState) |-> !gateEn);

  p_no_latch_idle_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    (!gateEn && !sleepState) |=> (sleepState || $stable(faultFlags)));

  p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    gateEn |=> (sleepState || ((faultFlags & $past(faultFlags)) == $past(faultFlags))));

endmodule

bind reset_sleep_ctrl reset_sleep_ctrl_chk #(.NUM_FAULTS(NUM_FAULTS)) u_chk (
  .clk       (clk),
  .sysRstN   (sysRstN),
  .pumpReady (pumpReady),
  .sleepState(sleepState),
  .circuitEn (circuitEn),
  .gateEn    (gateEn),
  .faultFlags(faultFlags)
);

// File: tb/tb_reset_sleep_ctrl.sv
module tb_reset_sleep_ctrl;

  localparam int P  = 6;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          sysRstN = 1'b0;
  logic          pinN = 1'b1;
  logic          pumpReady = 1'b0;
  logic [NF-1:0] faultEvt = '0;
  logic          sleepState, circuitEn, gateEn;
  logic [NF-1:0] faultFlags;

  int  total = 0;
  int  bad = 0;
  bit  sawSleep = 1'b0;
  bit  finished = 1'b0;
  logic [NF-1:0] expFlags = '0;

  always #10 clk = ~clk;

  reset_sleep_ctrl #(.PULSE_CYCLES(P), .NUM_FAULTS(NF)) dut (
    .clk(clk), .sysRstN(sysRstN), .pinN(pinN), .pumpReady(pumpReady),
    .faultEvt(faultEvt), .sleepState(sleepState), .circuitEn(circuitEn),
    .gateEn(gateEn), .faultFlags(faultFlags)
  );

  typedef struct packed {
    logic [7:0]    len;
    logic [NF-1:0] mask;
    logic          expSleep;
  } vec_s;

  localparam vec_s VECS [6] = '{
    '{8'd1,  4'b0001, 1'b0},
    '{8'd5,  4'b0010, 1'b0},
    '{8'd6,  4'b1000, 1'b0},
    '{8'd7,  4'b0100, 1'b1},
    '{8'd2,  4'b0011, 1'b0},
    '{8'd12, 4'b1111, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sleepState) sawSleep = 1'b1;
    end
  endtask

  task automatic lowPulse(input int len);
    pinN = 1'b0;
    tick(len);
    pinN = 1'b1;
  endtask

  task automatic injectFault(input logic [NF-1:0] m);
    faultEvt = m;
    tick(1);
    faultEvt = '0;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    sysRstN = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 sleep", sleepState, 0);
    check("R1 gateEn", gateEn, 0);
    check("R1 circuitEn", circuitEn, 1);
    check("R1 flags", faultFlags, 0);

    // R6 gate held off without pump ready
    tick(20);
    check("R6 gate off without pump", gateEn, 0);
    // R7 fault ignored while waiting
    injectFault(4'b1111);
    tick(1);
    check("R7 no latch while waiting", faultFlags, 0);
    pumpReady = 1'b1;
    tick(1);
    check("R6 gate on after pump", gateEn, 1);

    // table: pulse lengths around the limit (R2, R3, R5, R7)
    foreach (VECS[k]) begin
      injectFault(VECS[k].mask);
      expFlags |= VECS[k].mask;
      tick(1);
      check("R7 latch", faultFlags, expFlags);
      sawSleep = 1'b0;
      lowPulse(int'(VECS[k].len));
      tick(8);
      if (VECS[k].expSleep) expFlags = '0;
      check(VECS[k].expSleep ? "R3 sleep entered" : "R2 short pulse ignored",
            sawSleep, VECS[k].expSleep);
      check(VECS[k].expSleep ? "R5 flags cleared" : "R2 flags kept", faultFlags, expFlags);
      check("R6 back active", gateEn, 1);
    end

    // R3 exact timing: sleep appears after edge P+3
    pinN = 1'b0;
    tick(P + 2);
    check("R3 not yet asleep", sleepState, 0);
    tick(1);
    check("R3 asleep on time", sleepState, 1);
    // R4 enables dropped during sleep
    check("R4 circuitEn", circuitEn, 0);
    check("R4 gateEn", gateEn, 0);
    pumpReady = 1'b0;
    pinN = 1'b1;
    tick(5);
    check("R6 awake", sleepState, 0);
    check("R6 gate off while pump low", gateEn, 0);

    // R8 requalification during pump wait
    sawSleep = 1'b0;
    lowPulse(P);
    tick(8);
    check("R8 short pulse in wait ignored", sawSleep, 0);
    lowPulse(P + 1);
    tick(8);
    check("R8 long pulse in wait sleeps", sawSleep, 1);
    check("R8 still waiting", gateEn, 0);
    pumpReady = 1'b1;
    tick(1);
    check("R6 gate on", gateEn, 1);

    // R7 sticky accumulation
    injectFault(4'b0001);
    injectFault(4'b0100);
    tick(3);
    check("R7 sticky", faultFlags, 4'b0101);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule